// File: doc/BRIEF.md
# Adaptive Fundamental Magnitude Estimator

This block follows the fundamental component of a single sampled current with a two-weight adaptive linear neuron. Each accepted sample carries a signed current value and the matching sine and cosine reference values of the fundamental. The block forms the fundamental estimate from its present weights, takes the error against the measured current, nudges both weights along their own basis sample by a small learning rate, and then derives the fundamental magnitude as the square root of the summed squared weights. A three-phase system places one instance on each phase. The sine and cosine references come from outside.

Formats: the current is a signed integer of `DW` bits. The references are signed fractions with `DW-1` fraction bits, so 2^(DW-1)-1 stands for +1.0. The weights are signed `WW`-bit values in current units with `FRAC` fraction bits. The learning rate is the constant `LR_K / 2^LR_SH`. The default 629/2^20 is about 0.0006. Because sin² + cos² equals one, the normalising divide is left out and the rate is applied as a constant multiply.

A single state machine sequences the work. The states are ST_IDLE, ST_EST, ST_ADAPT, ST_SQUARE and ST_ROOT. The transitions are:
- accept: ST_IDLE to ST_EST, on a strobe or a held sample.
- estimate done: ST_EST to ST_ADAPT.
- adapt done: ST_ADAPT to ST_SQUARE.
- load root: ST_SQUARE to ST_ROOT.
- root done: ST_ROOT to ST_IDLE, when the bit-serial square-root unit reports completion after `WW` iterations.

Top module: `adaline_mag_top`

## Requirements
- R1: After reset, both weights, the magnitude and the estimate read zero, and all three valid flags are low.
- R2: For each accepted sample, `est_out` equals clamp(((Ws·sin + Wc·cos) >>> (DW-1)) >>> FRAC) to the signed DW-bit range. Ws and Wc are the weights held before that sample, `>>>` is an arithmetic (flooring) shift, and `est_valid` pulses for one cycle.
- R3: The error is e = (cur·2^FRAC) − ((Ws·sin + Wc·cos) >>> (DW-1)), taken with the old weights. Each weight becomes W + ((LR_K·e·basis) >>> (LR_SH+DW-1)), where basis is its own reference sample. The weights change only in the cycle in which `w_valid` pulses.
- R4: Each weight update clamps to [−2^(WW-1), 2^(WW-1)−1] and never wraps.
- R5: `mag_out` equals floor(sqrt(Ws² + Wc²)) of the updated weights, and `mag_valid` pulses once per completed square root.
- R6: A strobe that arrives while a sample is in progress is held and processed after `mag_valid`. If several arrive, the most recent one is kept and only it is processed.
- R7: For each accepted sample, `est_valid`, `w_valid` and `mag_valid` each pulse exactly once, in that order. No two of them are high together, and `w_valid` follows `est_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_strobe | input | 1 | Sample strobe |
| smp_cur | input | DW | Signed measured current sample |
| ref_sin | input | DW | Signed sine reference, DW-1 fraction bits |
| ref_cos | input | DW | Signed cosine reference, DW-1 fraction bits |
| est_out | output | DW | Estimated fundamental sample |
| est_valid | output | 1 | One-cycle pulse: est_out updated |
| w_sin | output | WW | Sine weight, FRAC fraction bits |
| w_cos | output | WW | Cosine weight, FRAC fraction bits |
| w_valid | output | 1 | One-cycle pulse: weights updated |
| mag_out | output | WW | Fundamental magnitude, FRAC fraction bits |
| mag_valid | output | 1 | One-cycle pulse: magnitude updated |

## Verification
The bench builds the block with DW=16, WW=20, FRAC=8 and a learning rate of 1/4 (LR_K=1, LR_SH=2). The large rate lets a full-scale current drive both weights into their clamps within a single sample. The narrow weight width puts the saturation bounds at ±2048 current units, so the bench can reach them without wide stimulus. The 20-iteration root leaves a window of more than twenty cycles in which held and overwritten strobes can be injected deliberately.

// File: rtl/adaline_mag_pkg.sv
package adaline_mag_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EST,
        ST_ADAPT,
        ST_SQUARE,
        ST_ROOT
    } amag_state_e;

endpackage

// File: rtl/adaline_est_mac.sv
module adaline_est_mac #(
    parameter int DW   = 16,
    parameter int WW   = 24,
    parameter int FRAC = 8,
    localparam int EW  = WW + DW + 2
) (
    input  logic signed [WW-1:0] w_s,
    input  logic signed [WW-1:0] w_c,
    input  logic signed [DW-1:0] b_sin,
    input  logic signed [DW-1:0] b_cos,
    input  logic signed [DW-1:0] cur,
    output logic signed [EW-1:0] err,
    output logic signed [DW-1:0] est_smp
);
    localparam logic signed [EW-1:0] DMAX = {{(EW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [EW-1:0] DMIN = ~DMAX;

    logic signed [EW-1:0] p_s, p_c, acc, est_w, cur_w, est_c;

    always_comb begin
        p_s   = EW'(w_s) * EW'(b_sin);
        p_c   = EW'(w_c) * EW'(b_cos);
        acc   = p_s + p_c;
        // estimate in weight scale (FRAC fraction bits)
        est_w = acc >>> (DW - 1);
        cur_w = EW'(cur) <<< FRAC;
        err   = cur_w - est_w;
        est_c = est_w >>> FRAC;
        if (est_c > DMAX)      est_smp = DMAX[DW-1:0];
        else if (est_c < DMIN) est_smp = DMIN[DW-1:0];
        else                   est_smp = est_c[DW-1:0];
    end
endmodule

// File: rtl/adaline_w_update.sv
module adaline_w_update #(
    parameter int DW    = 16,
    parameter int WW    = 24,
    parameter int LR_K  = 629,
    parameter int LR_SH = 20,
    parameter int LKW   = 16,
    localparam int EW   = WW + DW + 2,
    localparam int PW   = LKW + EW + DW
) (
    input  logic signed [WW-1:0] w_old,
    input  logic signed [EW-1:0] err,
    input  logic signed [DW-1:0] basis,
    output logic signed [WW-1:0] w_new
);
    localparam logic signed [LKW-1:0] LR_C = LKW'(LR_K);
    localparam logic signed [PW-1:0]  WMAX = {{(PW-WW+1){1'b0}}, {(WW-1){1'b1}}};
    localparam logic signed [PW-1:0]  WMIN = ~WMAX;

    logic signed [PW-1:0] prod, delta, sum;

    always_comb begin
        prod  = PW'(LR_C) * PW'(err) * PW'(basis);
        delta = prod >>> (LR_SH + DW - 1);
        sum   = PW'(w_old) + delta;
        if (sum > WMAX)      w_new = WMAX[WW-1:0];
        else if (sum < WMIN) w_new = WMIN[WW-1:0];
        else                 w_new = sum[WW-1:0];
    end
endmodule

// File: rtl/adaline_isqrt.sv
module adaline_isqrt #(
    parameter int WW  = 24,
    localparam int RW = 2 * WW,
    localparam int CW = $clog2(WW) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] radicand,
    output logic [WW-1:0] root,
    output logic          done
);
    logic [RW-1:0] op_q, res_q, one_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [RW-1:0] trial;

    assign trial = res_q + one_q;
    assign root  = res_q[WW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            res_q <= '0;
            one_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                op_q  <= radicand;
                res_q <= '0;
                one_q <= RW'(1) << (RW - 2);
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (op_q >= trial) begin
                    op_q  <= op_q - trial;
                    res_q <= (res_q >> 1) + one_q;
                end else begin
                    res_q <= res_q >> 1;
                end
                one_q <= one_q >> 2;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(WW - 1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adaline_mag_top.sv
module adaline_mag_top
    import adaline_mag_pkg::*;
#(
    parameter int DW    = 16,
    parameter int WW    = 24,
    parameter int FRAC  = 8,
    parameter int LR_K  = 629,
    parameter int LR_SH = 20,
    parameter int LKW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_strobe,
    input  logic signed [DW-1:0] smp_cur,
    input  logic signed [DW-1:0] ref_sin,
    input  logic signed [DW-1:0] ref_cos,
    output logic signed [DW-1:0] est_out,
    output logic                 est_valid,
    output logic signed [WW-1:0] w_sin,
    output logic signed [WW-1:0] w_cos,
    output logic                 w_valid,
    output logic        [WW-1:0] mag_out,
    output logic                 mag_valid
);
    localparam int EW = WW + DW + 2;
    localparam int RW = 2 * WW;

    amag_state_e state_q, state_d;

    // latched working sample and held (pending) sample
    logic signed [DW-1:0] cur_q, sin_q, cos_q;
    logic signed [DW-1:0] pcur_q, psin_q, pcos_q;
    logic                 pend_q;
    logic signed [EW-1:0] err_c, err_q;
    logic signed [DW-1:0] est_c;
    logic signed [WW-1:0] w_nxt [2];
    logic signed [DW-1:0] basis [2];
    logic signed [RW-1:0] sq_s, sq_c;
    logic        [RW-1:0] rad;
    logic        [WW-1:0] root;
    logic                 root_done;
    logic                 accept;

    assign accept = (state_q == ST_IDLE) && (smp_strobe || pend_q);

    adaline_est_mac #(.DW(DW), .WW(WW), .FRAC(FRAC)) mac_i (
        .w_s(w_sin), .w_c(w_cos), .b_sin(sin_q), .b_cos(cos_q),
        .cur(cur_q), .err(err_c), .est_smp(est_c)
    );

    assign basis[0] = sin_q;
    assign basis[1] = cos_q;

    for (genvar g = 0; g < 2; g++) begin : g_upd
        adaline_w_update #(
            .DW(DW), .WW(WW), .LR_K(LR_K), .LR_SH(LR_SH), .LKW(LKW)
        ) upd_i (
            .w_old((g == 0) ? w_sin : w_cos),
            .err(err_q), .basis(basis[g]), .w_new(w_nxt[g])
        );
    end

    always_comb begin
        sq_s = RW'(w_sin) * RW'(w_sin);
        sq_c = RW'(w_cos) * RW'(w_cos);
        rad  = $unsigned(sq_s) + $unsigned(sq_c);
    end

    adaline_isqrt #(.WW(WW)) sqrt_i (
        .clk(clk), .rst_n(rst_n), .start(state_q == ST_SQUARE),
        .radicand(rad), .root(root), .done(root_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_EST;
            ST_EST:    state_d = ST_ADAPT;
            ST_ADAPT:  state_d = ST_SQUARE;
            ST_SQUARE: state_d = ST_ROOT;
            ST_ROOT:   if (root_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q     <= '0;
            sin_q     <= '0;
            cos_q     <= '0;
            pcur_q    <= '0;
            psin_q    <= '0;
            pcos_q    <= '0;
            pend_q    <= 1'b0;
            err_q     <= '0;
            est_out   <= '0;
            est_valid <= 1'b0;
            w_sin     <= '0;
            w_cos     <= '0;
            w_valid   <= 1'b0;
            mag_out   <= '0;
            mag_valid <= 1'b0;
        end else begin
            est_valid <= 1'b0;
            w_valid   <= 1'b0;
            mag_valid <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (smp_strobe) begin
                    cur_q <= smp_cur;
                    sin_q <= ref_sin;
                    cos_q <= ref_cos;
                end else if (pend_q) begin
                    cur_q <= pcur_q;
                    sin_q <= psin_q;
                    cos_q <= pcos_q;
                end
                pend_q <= 1'b0;
            end else if (smp_strobe) begin
                pcur_q <= smp_cur;
                psin_q <= ref_sin;
                pcos_q <= ref_cos;
                pend_q <= 1'b1;
            end
            unique case (state_q)
                ST_EST: begin
                    err_q     <= err_c;
                    est_out   <= est_c;
                    est_valid <= 1'b1;
                end
                ST_ADAPT: begin
                    w_sin   <= w_nxt[0];
                    w_cos   <= w_nxt[1];
                    w_valid <= 1'b1;
                end
                ST_ROOT: begin
                    if (root_done) begin
                        mag_out   <= root;
                        mag_valid <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/adaline_mag_chk.sv
module adaline_mag_chk #(
    parameter int WW = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 est_valid,
    input logic                 w_valid,
    input logic                 mag_valid,
    input logic signed [WW-1:0] w_sin,
    input logic signed [WW-1:0] w_cos,
    input logic        [WW-1:0] mag_out
);
    localparam int XW = 2 * WW + 2;

    logic [XW-1:0] rad_x, m_sq, m1_sq;

    always_comb begin
        rad_x = XW'($unsigned(XW'(w_sin) * XW'(w_sin))) + XW'($unsigned(XW'(w_cos) * XW'(w_cos)));
        m_sq  = XW'(mag_out) * XW'(mag_out);
        m1_sq = (XW'(mag_out) + XW'(1)) * (XW'(mag_out) + XW'(1));
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (w_sin == '0 && w_cos == '0 && mag_out == '0 && !est_valid && !w_valid && !mag_valid));

    p_weights_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !w_valid |-> ($stable(w_sin) && $stable(w_cos)));

    p_root_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mag_valid |-> (m_sq <= rad_x && m1_sq > rad_x));

    p_flags_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({est_valid, w_valid, mag_valid}));

    p_est_then_w_r7: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |=> w_valid);
endmodule

bind adaline_mag_top adaline_mag_chk #(.WW(WW)) chk_i (
    .clk(clk), .rst_n(rst_n), .est_valid(est_valid), .w_valid(w_valid),
    .mag_valid(mag_valid), .w_sin(w_sin), .w_cos(w_cos), .mag_out(mag_out)
);

// File: tb/adaline_mag_top_tb_top.sv
module adaline_mag_top_tb_top;
    localparam int DW = 16, WW = 20, FRAC = 8, LRK = 1, LRSH = 2;
    localparam longint WMAX = (64'sd1 <<< (WW - 1)) - 1;
    localparam longint WMIN = -(64'sd1 <<< (WW - 1));

    logic clk = 1'b0, rst_n = 1'b0, smp_strobe = 1'b0;
    logic signed [DW-1:0] smp_cur = '0, ref_sin = '0, ref_cos = '0;
    logic signed [DW-1:0] est_out;
    logic signed [WW-1:0] w_sin, w_cos;
    logic [WW-1:0] mag_out;
    logic est_valid, w_valid, mag_valid;

    int checks = 0, errors = 0;
    longint cyc = 0;
    longint mws = 0, mwc = 0;   // model weights
    longint e_est, e_mag;

    always #5 clk = ~clk;

    adaline_mag_top #(.DW(DW), .WW(WW), .FRAC(FRAC), .LR_K(LRK), .LR_SH(LRSH), .LKW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .smp_cur(smp_cur),
        .ref_sin(ref_sin), .ref_cos(ref_cos), .est_out(est_out), .est_valid(est_valid),
        .w_sin(w_sin), .w_cos(w_cos), .w_valid(w_valid), .mag_out(mag_out), .mag_valid(mag_valid)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint clampw(input longint v);
        if (v > WMAX) return WMAX;
        if (v < WMIN) return WMIN;
        return v;
    endfunction

    function automatic longint isqrt(input longint v);
        longint lo = 0, hi = 64'sd1 << 21;
        while (lo < hi) begin
            longint mid = (lo + hi + 1) / 2;
            if (mid * mid <= v) lo = mid;
            else hi = mid - 1;
        end
        return lo;
    endfunction

    // model step: sets e_est, e_mag and updates mws, mwc
    task automatic model(input longint x, input longint s, input longint c);
        longint estw, err, ec;
        estw = (mws * s + mwc * c) >>> (DW - 1);
        err  = (x <<< FRAC) - estw;
        ec   = estw >>> FRAC;
        e_est = (ec > 32767) ? 32767 : ((ec < -32768) ? -32768 : ec);
        mws = clampw(mws + ((LRK * err * s) >>> (LRSH + DW - 1)));
        mwc = clampw(mwc + ((LRK * err * c) >>> (LRSH + DW - 1)));
        e_mag = isqrt(mws * mws + mwc * mwc);
    endtask

    task automatic drive(input longint x, input longint s, input longint c);
        @(negedge clk);
        smp_strobe = 1'b1; smp_cur = DW'(x); ref_sin = DW'(s); ref_cos = DW'(c);
        @(negedge clk);
        smp_strobe = 1'b0;
    endtask

    // waits for one full result; inj: 0 none, 1 one strobe, 2 two strobes (newest kept)
    task automatic wait_result(input string tag, input int inj,
                               input longint ax, input longint as_, input longint ac,
                               input longint bx, input longint bs, input longint bc);
        int ne = 0, nw = 0;
        bit got = 0;
        for (int i = 0; i < 80 && !got; i++) begin
            @(negedge clk);
            if (est_valid) begin
                ne++;
                chk(est_out == e_est, {tag, " R2 estimate"}, est_out, e_est);
            end
            if (w_valid) begin
                nw++;
                chk(w_sin == mws, {tag, " R3 sine weight"}, w_sin, mws);
                chk(w_cos == mwc, {tag, " R3 cosine weight"}, w_cos, mwc);
                if (inj >= 1) begin
                    smp_strobe = 1'b1; smp_cur = DW'(ax); ref_sin = DW'(as_); ref_cos = DW'(ac);
                    @(negedge clk);
                    if (inj == 2) begin
                        smp_cur = DW'(bx); ref_sin = DW'(bs); ref_cos = DW'(bc);
                        @(negedge clk);
                    end
                    smp_strobe = 1'b0;
                end
            end
            if (mag_valid) begin
                got = 1;
                chk(mag_out == e_mag, {tag, " R5 magnitude"}, mag_out, e_mag);
            end
        end
        chk(got && ne == 1 && nw == 1, {tag, " R7 one pulse of each flag"}, ne * 10 + nw, 11);
    endtask

    task automatic sample(input string tag, input longint x, input longint s, input longint c);
        drive(x, s, c);
        model(x, s, c);
        wait_result(tag, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        int seed;
        longint s, c, x;
        real th;
        seed = $urandom(32'd11);
        repeat (3) @(negedge clk);
        chk(w_sin == 0 && w_cos == 0, "R1 weights zero in reset", w_sin, 0);
        chk(mag_out == 0 && est_out == 0, "R1 outputs zero in reset", mag_out, 0);
        chk(!est_valid && !w_valid && !mag_valid, "R1 flags low in reset", est_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(w_sin == 0 && mag_out == 0 && !mag_valid, "R1 state after reset release", w_sin, 0);

        // directed first sample: zero weights give zero estimate
        sample("directed", 1000, 32767, 0);
        sample("directed cos", -500, 0, 32767);

        // sinusoid with harmonic and noise, random starting phase
        th = real'($urandom_range(0, 359)) * 3.14159265 / 180.0;
        for (int n = 0; n < 150; n++) begin
            real ph;
            ph = th + 2.0 * 3.14159265 * real'(n) / 40.0;
            s = longint'($rtoi(32767.0 * $sin(ph) + ((32767.0 * $sin(ph) >= 0.0) ? 0.5 : -0.5)));
            c = longint'($rtoi(32767.0 * $cos(ph) + ((32767.0 * $cos(ph) >= 0.0) ? 0.5 : -0.5)));
            x = longint'($rtoi(1500.0 * $sin(ph + 0.4) + 300.0 * $sin(5.0 * ph)))
                + longint'($urandom_range(0, 40)) - 20;
            sample("sinusoid", x, s, c);
        end

        // saturation toward both bounds
        for (int k = 0; k < 3; k++) sample("sat high", 32767, 32767, 32767);
        chk(w_sin == WMAX && w_cos == WMAX, "R4 weights clamp high", w_sin, WMAX);
        for (int k = 0; k < 3; k++) sample("sat low", -32768, 32767, 32767);
        chk(w_sin == WMIN && w_cos == WMIN, "R4 weights clamp low", w_sin, WMIN);
        sample("sat single", 32767, 32767, 0);
        chk(w_cos == WMIN, "R4 cosine weight untouched with zero basis", w_cos, WMIN);

        // held strobe during square root
        begin
            longint hx, hs, hc;
            drive(200, 23170, -23170);
            model(200, 23170, -23170);
            hx = -900; hs = 30000; hc = 13000;
            wait_result("hold A", 1, hx, hs, hc, 0, 0, 0);
            model(hx, hs, hc);
            wait_result("R6 held sample", 0, 0, 0, 0, 0, 0, 0);
        end

        // two strobes while busy: only the newest is processed
        begin
            int extra = 0;
            drive(100, 10000, 31000);
            model(100, 10000, 31000);
            wait_result("hold B", 2, 7000, 32767, 0, -3000, 0, -32767);
            model(-3000, 0, -32767);
            wait_result("R6 newest kept", 0, 0, 0, 0, 0, 0, 0);
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (est_valid) extra++;
            end
            chk(extra == 0, "R6 overwritten strobe not processed", extra, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule